// File: doc/BRIEF.md
# Shared Reorder Buffer Entry Allocator for Four Threads

This block manages the entries of one reorder buffer that up to four hardware threads share. Each cycle a rename stage offers up to two allocation requests, each tagged with a thread number. The block grants each request a free entry, provided the thread is active, has not been flushed in that cycle, and still sits below its share. An execution side marks entries complete by index. Completed entries retire, at most two per cycle across all threads, and each thread retires strictly in the order its entries were granted.

A thread's share is not fixed. The block recomputes it every cycle from the mask of active threads: the buffer depth divided by the number of active threads. A lone thread can therefore fill the whole buffer. Lowering the share never evicts anything: a thread above the new share simply stops receiving entries until retirement brings it back under. Both allocation and retirement choose threads in a rotating order, so no active thread is locked out. A per-thread flush drops all of that thread's entries in a single cycle.

Top module: `rob_thread_alloc`

## Requirements
- R1: After reset every thread's occupancy is 0, no retirement is offered and no stall is raised.
- R2: The sum of all thread occupancies never exceeds the buffer depth (72).
- R3: A thread's share is 72 divided by the number of active threads, rounded down (72, 36, 24, 18). A grant is given only if the thread's occupancy plus the grants it already received in the same cycle stays below that share. A single active thread can reach 72.
- R4: When the share drops below a thread's current occupancy, no entry of that thread is released. The thread's stall bit (active and occupancy at or above share) stays high and its requests are refused until it drains below the share, after which grants resume.
- R5: Up to two requests are granted per cycle. Free entries are handed out lowest index first, and the granted slots take them in slot order (slot 0 before slot 1).
- R6: A request whose thread bit is clear in the active mask is never granted.
- R7: Requests are served by thread in rotating order. The search starts at the thread one past the last thread granted. The ordering depends on thread number, not slot, and a thread that is refused keeps its place.
- R8: An entry retires only when it is complete and every older entry of its thread has already retired. A thread may retire two entries in one cycle. The retire outputs appear one cycle after completion is presented.
- R9: A completion aimed at a free entry, or at an index of 72 or above, changes nothing. An entry allocated later at that index still waits for its own completion.
- R10: A flush of a thread sets its occupancy to 0 in the next cycle and refuses its allocations in that cycle. Other threads' entries and grants are untouched.
- R11: At most two entries retire per cycle across all threads. Ready entries beyond that limit retire in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_active | input | 4 | Active thread mask, bit t for thread t |
| alloc_valid | input | 2 | Allocation request per slot |
| alloc_tid | input | 4 | Thread number per slot, 2 bits each, slot 0 in the low bits |
| alloc_grant | output | 2 | Grant per slot, same cycle as the request |
| alloc_idx | output | 14 | Entry index given to each granted slot, 7 bits each |
| cmpl_valid | input | 2 | Completion strobe per lane |
| cmpl_idx | input | 14 | Index completed on each lane, 7 bits each |
| flush_req | input | 4 | Flush request per thread |
| ret_valid | output | 2 | Retirement offered per lane, lane 0 first |
| ret_idx | output | 14 | Index retired on each lane |
| ret_tid | output | 4 | Thread of each retired entry |
| occupancy | output | 28 | Entries held per thread, 7 bits each |
| thr_stall | output | 4 | Thread is active and at or above its share |

## Verification
The assertions assume that the rename stage accepts every grant in the cycle it is given, that the execution side never completes an entry twice, and that completions name indices returned by earlier grants, apart from the deliberate stray completions. The bench keeps to these assumptions. It completes each captured index exactly once, holds requests for exactly the cycles it means to, and changes the active mask only while no requests are offered. A reference model built from the grant and retire ports tracks the entries each thread holds. Against that model the bench checks the occupancy ports, the share limit at every grant, and the order of every retirement.

// File: rtl/rob_pkg.sv
package rob_pkg;
    localparam int unsigned ROB_ENTRIES = 72;
    localparam int unsigned ROB_THREADS = 4;
    localparam int unsigned ROB_LANES   = 2;

    // position reached by stepping off places around a ring of n threads
    function automatic int unsigned ring_step(input int unsigned base,
                                              input int unsigned off,
                                              input int unsigned n);
        return (base + off) % n;
    endfunction
endpackage

// File: rtl/rob_free_pick.sv
module rob_free_pick #(
    parameter int unsigned DEPTH = 72,
    parameter int unsigned LANES = 2,
    parameter int unsigned IW    = 7
) (
    input  logic [DEPTH-1:0]    busy,
    output logic [LANES-1:0]    ok,
    output logic [LANES*IW-1:0] idx
);
    logic [DEPTH-1:0] avail;

    // lowest free index per lane; each lane removes its pick before the next
    always_comb begin
        avail = ~busy;
        ok    = '0;
        idx   = '0;
        for (int l = 0; l < int'(LANES); l++) begin
            for (int i = int'(DEPTH) - 1; i >= 0; i--) begin
                if (avail[i]) begin
                    ok[l]            = 1'b1;
                    idx[l*IW +: IW]  = IW'(i);
                end
            end
            for (int i = 0; i < int'(DEPTH); i++) begin
                if (ok[l] && idx[l*IW +: IW] == IW'(i)) avail[i] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/rob_alloc_arb.sv
module rob_alloc_arb
    import rob_pkg::*;
#(
    parameter int unsigned THREADS = 4,
    parameter int unsigned LANES   = 2,
    parameter int unsigned TW      = 2,
    parameter int unsigned CW      = 7
) (
    input  logic [LANES-1:0]      req_valid,
    input  logic [LANES*TW-1:0]   req_tid,
    input  logic [THREADS-1:0]    active,
    input  logic [THREADS-1:0]    flush,
    input  logic [THREADS*CW-1:0] occ,
    input  logic [CW-1:0]         cap,
    input  logic [LANES-1:0]      free_ok,
    input  logic [TW-1:0]         rr_ptr,
    output logic [LANES-1:0]      grant,
    output logic [TW-1:0]         rr_next
);
    logic [CW-1:0]   taken [THREADS];
    logic [LANES:0]  okx;
    int unsigned     used;
    int unsigned     t;

    // visit slots by thread distance from the pointer; ties keep slot order
    always_comb begin
        grant   = '0;
        rr_next = rr_ptr;
        used    = 0;
        t       = 0;
        okx     = {1'b0, free_ok};
        for (int k = 0; k < int'(THREADS); k++) taken[k] = '0;
        for (int d = 0; d < int'(THREADS); d++) begin
            for (int s = 0; s < int'(LANES); s++) begin
                t = 32'(req_tid[s*TW +: TW]);
                if (req_valid[s] && t == ring_step(32'(rr_ptr), d, THREADS)) begin
                    if (active[t] && !flush[t] && okx[used] &&
                        ({1'b0, occ[t*CW +: CW]} + {1'b0, taken[t]}) < {1'b0, cap}) begin
                        grant[s]  = 1'b1;
                        taken[t]  = taken[t] + 1'b1;
                        used      = used + 1;
                        rr_next   = TW'(ring_step(t, 1, THREADS));
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rob_retire_sel.sv
module rob_retire_sel
    import rob_pkg::*;
#(
    parameter int unsigned DEPTH   = 72,
    parameter int unsigned THREADS = 4,
    parameter int unsigned LANES   = 2,
    parameter int unsigned TW      = 2,
    parameter int unsigned IW      = 7,
    parameter int unsigned CW      = 7
) (
    input  logic [DEPTH-1:0]      done,
    input  logic [DEPTH*IW-1:0]   link,
    input  logic [THREADS*IW-1:0] head,
    input  logic [THREADS*CW-1:0] occ,
    input  logic [THREADS-1:0]    block,
    input  logic [TW-1:0]         rr_ptr,
    output logic [LANES-1:0]      ret_valid,
    output logic [LANES*IW-1:0]   ret_idx,
    output logic [LANES*TW-1:0]   ret_tid,
    output logic [TW-1:0]         rr_next
);
    int unsigned used;
    int unsigned t;
    logic [IW-1:0] cur;
    logic          go;

    // walk each thread's chain from its head, rotating start thread
    always_comb begin
        ret_valid = '0;
        ret_idx   = '0;
        ret_tid   = '0;
        rr_next   = rr_ptr;
        used      = 0;
        t         = 0;
        cur       = '0;
        go        = 1'b0;
        for (int d = 0; d < int'(THREADS); d++) begin
            t   = ring_step(32'(rr_ptr), d, THREADS);
            cur = head[t*IW +: IW];
            go  = !block[t];
            for (int k = 0; k < int'(LANES); k++) begin
                if (go && used < LANES && occ[t*CW +: CW] > CW'(k) &&
                    32'(cur) < DEPTH && done[cur]) begin
                    ret_valid[used]            = 1'b1;
                    ret_idx[used*IW +: IW]     = cur;
                    ret_tid[used*TW +: TW]     = TW'(t);
                    used                       = used + 1;
                    rr_next                    = TW'(ring_step(t, 1, THREADS));
                    cur                        = link[32'(cur)*IW +: IW];
                end else begin
                    go = 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/rob_thread_alloc.sv
module rob_thread_alloc
    import rob_pkg::*;
#(
    parameter int unsigned DEPTH = ROB_ENTRIES,
    parameter int unsigned NT    = ROB_THREADS,
    parameter int unsigned L     = ROB_LANES,
    localparam int unsigned TW   = (NT > 1) ? $clog2(NT) : 1,
    localparam int unsigned IW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NT-1:0]    thr_active,
    input  logic [L-1:0]     alloc_valid,
    input  logic [L*TW-1:0]  alloc_tid,
    output logic [L-1:0]     alloc_grant,
    output logic [L*IW-1:0]  alloc_idx,
    input  logic [L-1:0]     cmpl_valid,
    input  logic [L*IW-1:0]  cmpl_idx,
    input  logic [NT-1:0]    flush_req,
    output logic [L-1:0]     ret_valid,
    output logic [L*IW-1:0]  ret_idx,
    output logic [L*TW-1:0]  ret_tid,
    output logic [NT*CW-1:0] occupancy,
    output logic [NT-1:0]    thr_stall
);
    typedef struct packed {
        logic [DEPTH-1:0]          vld;
        logic [DEPTH-1:0]          done;
        logic [DEPTH-1:0][TW-1:0]  tid;
        logic [DEPTH-1:0][IW-1:0]  link;
        logic [NT-1:0][IW-1:0]     head;
        logic [NT-1:0][IW-1:0]     tail;
        logic [NT-1:0][CW-1:0]     occ;
        logic [TW-1:0]             arr;
        logic [TW-1:0]             rrr;
    } state_t;

    state_t s_d, s_q;

    logic [L-1:0]    free_ok;
    logic [L*IW-1:0] free_idx;
    logic [TW-1:0]   arb_rr_d, ret_rr_d;
    logic [CW-1:0]   cap;
    logic [NT-1:0]   thr_gnt;
    logic [IW-1:0]   fi, ri;
    logic [TW-1:0]   ft, rt;
    int unsigned     nact;
    int unsigned     k;
    int unsigned     occ_sum;

    rob_free_pick #(.DEPTH(DEPTH), .LANES(L), .IW(IW)) u_pick (
        .busy (s_q.vld),
        .ok   (free_ok),
        .idx  (free_idx)
    );

    rob_alloc_arb #(.THREADS(NT), .LANES(L), .TW(TW), .CW(CW)) u_arb (
        .req_valid (alloc_valid),
        .req_tid   (alloc_tid),
        .active    (thr_active),
        .flush     (flush_req),
        .occ       (s_q.occ),
        .cap       (cap),
        .free_ok   (free_ok),
        .rr_ptr    (s_q.arr),
        .grant     (alloc_grant),
        .rr_next   (arb_rr_d)
    );

    rob_retire_sel #(.DEPTH(DEPTH), .THREADS(NT), .LANES(L), .TW(TW), .IW(IW), .CW(CW)) u_ret (
        .done      (s_q.done),
        .link      (s_q.link),
        .head      (s_q.head),
        .occ       (s_q.occ),
        .block     (flush_req),
        .rr_ptr    (s_q.rrr),
        .ret_valid (ret_valid),
        .ret_idx   (ret_idx),
        .ret_tid   (ret_tid),
        .rr_next   (ret_rr_d)
    );

    // share from the active mask, stall per thread
    always_comb begin
        nact = 32'($countones(thr_active));
        cap  = (nact == 0) ? CW'(DEPTH) : CW'(DEPTH / nact);
        for (int t = 0; t < int'(NT); t++)
            thr_stall[t] = thr_active[t] && (s_q.occ[t] >= cap);
        occupancy = s_q.occ;
        occ_sum   = 0;
        for (int t = 0; t < int'(NT); t++) occ_sum = occ_sum + 32'(s_q.occ[t]);
    end

    // next state: completions, retirements, flushes, then allocations
    always_comb begin
        s_d       = s_q;
        alloc_idx = '0;
        thr_gnt   = '0;
        k         = 0;
        fi        = '0;
        ft        = '0;
        ri        = '0;
        rt        = '0;
        for (int l = 0; l < int'(L); l++) begin
            ri = cmpl_idx[l*IW +: IW];
            if (cmpl_valid[l] && ri < IW'(DEPTH) && s_q.vld[ri]) s_d.done[ri] = 1'b1;
        end
        for (int l = 0; l < int'(L); l++) begin
            if (ret_valid[l]) begin
                ri             = ret_idx[l*IW +: IW];
                rt             = ret_tid[l*TW +: TW];
                s_d.vld[ri]    = 1'b0;
                s_d.done[ri]   = 1'b0;
                s_d.occ[rt]    = s_d.occ[rt] - 1'b1;
                s_d.head[rt]   = s_q.link[ri];
            end
        end
        for (int t = 0; t < int'(NT); t++) begin
            if (flush_req[t]) begin
                for (int i = 0; i < int'(DEPTH); i++) begin
                    if (s_q.vld[i] && s_q.tid[i] == TW'(t)) begin
                        s_d.vld[i]  = 1'b0;
                        s_d.done[i] = 1'b0;
                    end
                end
                s_d.occ[t] = '0;
            end
        end
        for (int s = 0; s < int'(L); s++) begin
            if (alloc_grant[s]) begin
                fi                     = free_idx[k*IW +: IW];
                ft                     = alloc_tid[s*TW +: TW];
                k                      = k + 1;
                alloc_idx[s*IW +: IW]  = fi;
                thr_gnt[ft]            = 1'b1;
                s_d.vld[fi]            = 1'b1;
                s_d.done[fi]           = 1'b0;
                s_d.tid[fi]            = ft;
                if (s_d.occ[ft] == '0) s_d.head[ft] = fi;
                else                   s_d.link[s_d.tail[ft]] = fi;
                s_d.tail[ft]           = fi;
                s_d.occ[ft]            = s_d.occ[ft] + 1'b1;
            end
        end
        s_d.arr = arb_rr_d;
        s_d.rrr = ret_rr_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2: buffer never over-committed
    p_total_depth_r2: assert property (@(posedge clk) disable iff (!rst_n)
        occ_sum <= DEPTH);

    for (genvar t = 0; t < NT; t++) begin : g_thr
        // R3: occupancy after a grant stays within the share in force
        p_share_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
            thr_gnt[t] |=> s_q.occ[t] <= $past(cap));
        // R10: flush empties the thread
        p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
            flush_req[t] |=> s_q.occ[t] == '0);
    end

    for (genvar s = 0; s < L; s++) begin : g_lane
        // R6: only active threads are granted
        p_active_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
            alloc_grant[s] |-> thr_active[alloc_tid[s*TW +: TW]]);
        // R5: granted entry was free
        p_free_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
            alloc_grant[s] |-> !s_q.vld[alloc_idx[s*IW +: IW]]);
        // R8: retired entry is live, complete and owned by the reported thread
        p_retire_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ret_valid[s] |-> (s_q.vld[ret_idx[s*IW +: IW]] && s_q.done[ret_idx[s*IW +: IW]] &&
                              s_q.tid[ret_idx[s*IW +: IW]] == ret_tid[s*TW +: TW]));
    end
endmodule

// File: tb/rob_thread_alloc_test.sv
`timescale 1ns/1ps
module rob_thread_alloc_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  thr_active = '0;
    logic [1:0]  alloc_valid = '0;
    logic [3:0]  alloc_tid = '0;
    logic [1:0]  alloc_grant;
    logic [13:0] alloc_idx;
    logic [1:0]  cmpl_valid = '0;
    logic [13:0] cmpl_idx = '0;
    logic [3:0]  flush_req = '0;
    logic [1:0]  ret_valid;
    logic [13:0] ret_idx;
    logic [3:0]  ret_tid;
    logic [27:0] occupancy;
    logic [3:0]  thr_stall;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;
    bit mon_en = 0;

    always #2.5 clk = ~clk;

    rob_thread_alloc uut (
        .clk(clk), .rst_n(rst_n), .thr_active(thr_active),
        .alloc_valid(alloc_valid), .alloc_tid(alloc_tid),
        .alloc_grant(alloc_grant), .alloc_idx(alloc_idx),
        .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx), .flush_req(flush_req),
        .ret_valid(ret_valid), .ret_idx(ret_idx), .ret_tid(ret_tid),
        .occupancy(occupancy), .thr_stall(thr_stall)
    );

    // {mask[15:12], 2'b0, thread[9:8], stall[7], occ[6:0]}
    localparam logic [15:0] TBL [5] = '{
        {4'b0001, 2'b00, 2'd0, 1'b1, 7'd72},
        {4'b0011, 2'b00, 2'd1, 1'b1, 7'd36},
        {4'b0111, 2'b00, 2'd2, 1'b1, 7'd24},
        {4'b1111, 2'b00, 2'd3, 1'b1, 7'd18},
        {4'b1110, 2'b00, 2'd0, 1'b0, 7'd0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc;
        @(posedge clk);
        #1;
    endtask

    function automatic int occ_of(input int t);
        return int'(occupancy[t*7 +: 7]);
    endfunction

    function automatic int share(input logic [3:0] m);
        int n;
        n = $countones(m);
        return (n == 0) ? 72 : 72 / n;
    endfunction

    task automatic req(input logic [1:0] v, input int t0, input int t1);
        alloc_valid = v;
        alloc_tid   = {2'(t1), 2'(t0)};
    endtask

    task automatic cmpl(input logic [1:0] v, input int i0, input int i1);
        cmpl_valid = v;
        cmpl_idx   = {7'(i1), 7'(i0)};
    endtask

    task automatic flush_all;
        alloc_valid = '0;
        flush_req   = 4'hF;
        cyc();
        flush_req   = '0;
    endtask

    // reference model: per-thread queues of granted indices
    int mq [4][128];
    int mh [4];
    int mt [4];

    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            int pre [4];
            int tot;
            int extra [4];
            tot = 0;
            for (int t = 0; t < 4; t++) begin
                pre[t]   = mt[t] - mh[t];
                extra[t] = 0;
                tot      = tot + pre[t];
                chk(occ_of(t) == pre[t], "R2 occupancy model", occ_of(t), pre[t]);
            end
            chk(tot <= 72, "R2 total", tot, 72);
            for (int l = 0; l < 2; l++) begin
                if (ret_valid[l]) begin
                    int t;
                    int e;
                    t = int'(ret_tid[l*2 +: 2]);
                    e = (mh[t] < mt[t]) ? mq[t][mh[t] % 128] : -1;
                    chk(int'(ret_idx[l*7 +: 7]) == e, "R8 retire order", int'(ret_idx[l*7 +: 7]), e);
                    if (mh[t] < mt[t]) mh[t]++;
                end
            end
            for (int t = 0; t < 4; t++) if (flush_req[t]) mh[t] = mt[t];
            for (int s = 0; s < 2; s++) begin
                if (alloc_grant[s]) begin
                    int t;
                    t = int'(alloc_tid[s*2 +: 2]);
                    chk(pre[t] + extra[t] < share(thr_active), "R3 share at grant",
                        pre[t] + extra[t], share(thr_active));
                    extra[t]++;
                    mq[t][mt[t] % 128] = int'(alloc_idx[s*7 +: 7]);
                    mt[t]++;
                end
            end
        end
    end

    initial begin
        #750000;
        if (!finished) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < 4; t++) begin mh[t] = 0; mt[t] = 0; end
        repeat (3) cyc();
        rst_n = 1'b1;
        thr_active = 4'hF;
        @(negedge clk);
        // R1 reset state
        chk(occupancy == '0, "R1 occupancy", int'(occupancy), 0);
        chk(ret_valid == '0, "R1 retire", int'(ret_valid), 0);
        chk(thr_stall == '0, "R1 stall", int'(thr_stall), 0);
        mon_en = 1'b1;

        // table walk: R3 share per active count, R6 inactive thread
        for (int r = 0; r < 5; r++) begin
            logic [15:0] row;
            int th;
            row = TBL[r];
            flush_all();
            thr_active = row[15:12];
            th = int'(row[9:8]);
            req(2'b11, th, th);
            repeat (40) cyc();
            alloc_valid = '0;
            @(negedge clk);
            chk(occ_of(th) == int'(row[6:0]), "R3 R6 fill level", occ_of(th), int'(row[6:0]));
            chk(thr_stall[th] == row[7], "R4 stall at share", int'(thr_stall[th]), int'(row[7]));
        end

        // R5 and R8: ordering of retirement
        flush_all();
        thr_active = 4'b0001;
        req(2'b11, 0, 0);
        @(negedge clk);
        chk(alloc_grant == 2'b11, "R5 dual grant", int'(alloc_grant), 3);
        chk(alloc_idx == {7'd1, 7'd0}, "R5 lowest free", int'(alloc_idx), 128);
        cyc();
        cyc();
        alloc_valid = '0;
        cmpl(2'b11, 3, 2);
        cyc();
        cmpl(2'b00, 0, 0);
        @(negedge clk);
        chk(ret_valid == 2'b00, "R8 younger done waits", int'(ret_valid), 0);
        cmpl(2'b01, 0, 0);
        cyc();
        cmpl(2'b00, 0, 0);
        @(negedge clk);
        chk(ret_valid == 2'b01 && ret_idx[6:0] == 7'd0, "R8 oldest retires", int'(ret_idx[6:0]), 0);
        cyc();
        @(negedge clk);
        chk(ret_valid == 2'b00, "R8 gap blocks", int'(ret_valid), 0);
        cmpl(2'b01, 1, 0);
        cyc();
        cmpl(2'b00, 0, 0);
        @(negedge clk);
        chk(ret_valid == 2'b11 && ret_idx == {7'd2, 7'd1}, "R8 two in order", int'(ret_idx), 257);
        cyc();
        @(negedge clk);
        chk(ret_valid == 2'b01 && ret_idx[6:0] == 7'd3, "R8 last", int'(ret_idx[6:0]), 3);
        cyc();
        @(negedge clk);
        chk(occ_of(0) == 0, "R8 drained", occ_of(0), 0);

        // R9 stray completions
        cmpl(2'b11, 0, 100);
        cyc();
        cmpl(2'b00, 0, 0);
        req(2'b01, 0, 0);
        @(negedge clk);
        chk(alloc_grant == 2'b01 && alloc_idx[6:0] == 7'd0, "R9 reuse index 0", int'(alloc_idx[6:0]), 0);
        cyc();
        alloc_valid = '0;
        cyc();
        @(negedge clk);
        chk(ret_valid == 2'b00, "R9 stray completion ignored", int'(ret_valid), 0);
        chk(occ_of(0) == 1, "R9 entry held", occ_of(0), 1);
        cmpl(2'b01, 0, 0);
        cyc();
        cmpl(2'b00, 0, 0);
        @(negedge clk);
        chk(ret_valid == 2'b01, "R9 real completion retires", int'(ret_valid), 1);
        cyc();

        // R4 lowered share without eviction
        flush_all();
        req(2'b11, 0, 0);
        repeat (20) cyc();
        alloc_valid = '0;
        thr_active = 4'b0011;
        @(negedge clk);
        chk(occ_of(0) == 40, "R4 no eviction", occ_of(0), 40);
        chk(thr_stall[0] == 1'b1, "R4 stall over share", int'(thr_stall[0]), 1);
        req(2'b01, 0, 0);
        #0.1;
        chk(alloc_grant == 2'b00, "R4 refused over share", int'(alloc_grant), 0);
        alloc_valid = '0;
        cmpl(2'b11, 0, 1);
        cyc();
        cmpl(2'b11, 2, 3);
        cyc();
        cmpl(2'b01, 4, 0);
        cyc();
        cmpl(2'b00, 0, 0);
        repeat (3) cyc();
        @(negedge clk);
        chk(occ_of(0) == 35, "R4 drained below", occ_of(0), 35);
        chk(thr_stall[0] == 1'b0, "R4 stall released", int'(thr_stall[0]), 0);
        req(2'b01, 0, 0);
        #0.1;
        chk(alloc_grant == 2'b01, "R4 grant resumes", int'(alloc_grant), 1);
        cyc();
        alloc_valid = '0;
        @(negedge clk);
        chk(thr_stall[0] == 1'b1, "R4 at share again", int'(thr_stall[0]), 1);

        // R10 flush one thread
        req(2'b11, 1, 1);
        cyc();
        cyc();
        flush_req = 4'b0001;
        req(2'b11, 0, 1);
        @(negedge clk);
        chk(alloc_grant == 2'b10, "R10 flushed thread refused", int'(alloc_grant), 2);
        cyc();
        flush_req = '0;
        alloc_valid = '0;
        @(negedge clk);
        chk(occ_of(0) == 0, "R10 thread emptied", occ_of(0), 0);
        chk(occ_of(1) == 5, "R10 other thread kept", occ_of(1), 5);

        // R7 rotating priority with one free entry
        flush_all();
        thr_active = 4'b0001;
        req(2'b11, 0, 0);
        repeat (35) cyc();
        req(2'b01, 0, 0);
        cyc();
        alloc_valid = '0;
        thr_active = 4'b0110;
        req(2'b11, 2, 1);
        @(negedge clk);
        chk(alloc_grant == 2'b10, "R7 thread 1 first", int'(alloc_grant), 2);
        cyc();
        alloc_valid = '0;
        cmpl(2'b01, 0, 0);
        cyc();
        cmpl(2'b00, 0, 0);
        cyc();
        req(2'b11, 2, 1);
        @(negedge clk);
        chk(alloc_grant == 2'b01, "R7 thread 2 next", int'(alloc_grant), 1);
        chk(alloc_idx[6:0] == 7'd0, "R5 freed index reused", int'(alloc_idx[6:0]), 0);
        cyc();
        alloc_valid = '0;

        // R11 retirement limit
        flush_all();
        thr_active = 4'b0011;
        req(2'b11, 0, 1);
        cyc();
        cyc();
        alloc_valid = '0;
        cmpl(2'b11, 2, 3);
        cyc();
        cmpl(2'b11, 0, 1);
        cyc();
        cmpl(2'b00, 0, 0);
        @(negedge clk);
        chk(ret_valid == 2'b11, "R11 two of four", int'(ret_valid), 3);
        cyc();
        @(negedge clk);
        chk(ret_valid == 2'b11, "R11 remaining two", int'(ret_valid), 3);
        cyc();
        @(negedge clk);
        chk(ret_valid == 2'b00 && occupancy == '0, "R11 all retired", int'(occupancy), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule